// File: doc/BRIEF.md
# DSP Immediate Shift Unit

This unit performs arithmetic shifts by an immediate count for a DSP datapath. It has two modes. In half mode it takes one 16-bit half of a 32-bit source register and shifts it. A single 5-bit count encodes both directions: a count above 16 shifts left by 32 minus the count, and any other count shifts right arithmetically. A left shift that does not fit in a signed 16-bit value saturates. The destination half selection is carried alongside the result so the register file can write it back.

In accumulator mode the unit joins an 8-bit extension byte and a 32-bit word into one signed 40-bit accumulator value. It shifts that value right arithmetically and returns the result split back into extension and word. One of two accumulators is selected by an index.

Every accepted operation produces its result and its status flag updates one clock after the input strobe. The flag updates are given as a value plus a write enable per flag. The sticky overflow flag has a set-only strobe, and each accumulator's overflow flag has a clear strobe.

Top module: `dsp_imm_shift`

## Requirements
- R1: In half mode (`mode_i`=0), a count of 17..31 shifts the selected half left by 32 minus the count, and the low 16 bits become the result when no overflow occurs.
- R2: In half mode, a count of 0..16 shifts the selected half right arithmetically by the count. A count of 0 returns the operand unchanged, and a count of 16 returns 16 copies of its bit 15.
- R3: A left shift overflows when the shifted value, taken as a signed number, does not fit in 16 bits. This happens when any bit pushed out above bit 15 differs from the sign, or when result bit 15 differs from input bit 15. On overflow the result is 0x8000 for a negative operand and 0x7FFF otherwise.
- R4: On a left shift, `v_we_o`=1 and `v_o` equals the overflow. `vs_set_o`=1 only on overflow, so the sticky flag is never cleared.
- R5: On a left shift, `az_we_o`=`an_we_o`=1, `az_o`=1 exactly when the 16-bit result is zero, and `an_o` equals result bit 15.
- R6: A half-mode right shift raises no flag write enable and no sticky set.
- R7: `src_hi_i`=1 selects source bits 31:16 as the operand and `src_hi_i`=0 selects bits 15:0. `dst_hi_o` returns `dst_hi_i` with the result.
- R8: In accumulator mode (`mode_i`=1), {`acc_ext_i`,`acc_word_i`} is a signed 40-bit value. It is shifted right arithmetically by the 5-bit count, filling with copies of bit 39. Result bits 39:32 go to `acc_ext_o` and bits 31:0 go to `acc_word_o`.
- R9: In accumulator mode, `an_o` equals result bit 39, `az_o`=1 exactly when all 40 result bits are zero, `az_we_o`=`an_we_o`=1, and `v_we_o`=`vs_set_o`=0.
- R10: `acc_idx_i` selects the accumulator and returns on `acc_idx_o`. In accumulator mode `av_clr_o` has exactly bit `acc_idx_i` set. In half mode it is zero.
- R11: Results and strobes appear on the clock after `valid_i`=1 with `valid_o`=1. In a cycle with no input strobe, all write and flag strobes are 0.
- R12: After reset, `valid_o` and every write and flag strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 1 | 0 = half shift, 1 = accumulator shift |
| src_word_i | input | 32 | Source register holding both halves |
| src_hi_i | input | 1 | Use the high half as the operand |
| dst_hi_i | input | 1 | Result targets the high destination half |
| count_i | input | 5 | Immediate shift count |
| acc_idx_i | input | 1 | Accumulator index |
| acc_ext_i | input | 8 | Accumulator extension byte |
| acc_word_i | input | 32 | Accumulator low word |
| valid_o | output | 1 | Result strobe |
| half_wr_o | output | 1 | Half result write enable |
| dst_hi_o | output | 1 | Destination half select |
| half_res_o | output | 16 | Half-mode result |
| acc_wr_o | output | 1 | Accumulator write enable |
| acc_idx_o | output | 1 | Accumulator written |
| acc_ext_o | output | 8 | Result extension byte |
| acc_word_o | output | 32 | Result low word |
| az_we_o | output | 1 | Zero flag write enable |
| az_o | output | 1 | Zero flag value |
| an_we_o | output | 1 | Negative flag write enable |
| an_o | output | 1 | Negative flag value |
| v_we_o | output | 1 | Overflow flag write enable |
| v_o | output | 1 | Overflow flag value |
| vs_set_o | output | 1 | Sticky overflow set |
| av_clr_o | output | 2 | Per-accumulator overflow clear |

## Verification
The hardest case to reach is a left shift that overflows only because bit 15 changes while no bit pushed past bit 15 disagrees with the sign, for example 0x4000 or 0xBFFF shifted by one. The mirror case is also needed: a shift that lands exactly on 0x8000 without overflowing, such as 0xC000 by one or 0xFFFF by fifteen. The vector table places these operands beside each other, so a wrong fit test changes the result and the overflow strobe. The same table sends one source word through both half selects with different outcomes, which exposes a swapped half mux.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;
  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_ACC  = 1'b1
  } shift_mode_e;

  typedef struct packed {
    logic az_we;
    logic az;
    logic an_we;
    logic an;
    logic v_we;
    logic v;
    logic vs_set;
  } flag_upd_t;
endpackage

// File: rtl/half_shifter.sv
module half_shifter #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [HALF_W-1:0] op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [HALF_W-1:0] res_o,
  output logic              left_o,
  output logic              ovf_o
);
  localparam int EXT_W = 2 * HALF_W;

  logic signed [EXT_W-1:0] ext_op;
  logic signed [EXT_W-1:0] shl;
  logic signed [EXT_W-1:0] shr;
  logic [CNT_W:0]          lamt;
  logic [EXT_W-HALF_W:0]   upper;
  logic [HALF_W-1:0]       sat;

  assign ext_op = {{HALF_W{op_i[HALF_W-1]}}, op_i};
  assign left_o = cnt_i > CNT_W'(HALF_W);
  assign lamt   = (CNT_W+1)'(EXT_W) - {1'b0, cnt_i};
  assign shl    = ext_op << lamt;
  assign shr    = ext_op >>> cnt_i;

  // result fits only if bit 15 and everything above it agree
  assign upper  = shl[EXT_W-1:HALF_W-1];
  assign ovf_o  = left_o && !((&upper) || (~|upper));

  assign sat    = op_i[HALF_W-1] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};

  always_comb begin
    if (!left_o)    res_o = shr[HALF_W-1:0];
    else if (ovf_o) res_o = sat;
    else            res_o = shl[HALF_W-1:0];
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [EXT_W-1:0]  ext_o,
  output logic [WORD_W-1:0] word_o,
  output logic              neg_o,
  output logic              zero_o
);
  localparam int ACC_W = EXT_W + WORD_W;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] sh;

  assign acc    = {ext_i, word_i};
  assign sh     = acc >>> cnt_i;
  assign ext_o  = sh[ACC_W-1:WORD_W];
  assign word_o = sh[WORD_W-1:0];
  assign neg_o  = sh[ACC_W-1];
  assign zero_o = ~|sh;
endmodule

// File: rtl/dsp_imm_shift.sv
module dsp_imm_shift
  import dsp_shift_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int EXT_W   = 8,
  parameter int CNT_W   = 5,
  parameter int NUM_ACC = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       mode_i,
  input  logic [2*HALF_W-1:0]        src_word_i,
  input  logic                       src_hi_i,
  input  logic                       dst_hi_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic [$clog2(NUM_ACC)-1:0] acc_idx_i,
  input  logic [EXT_W-1:0]           acc_ext_i,
  input  logic [2*HALF_W-1:0]        acc_word_i,
  output logic                       valid_o,
  output logic                       half_wr_o,
  output logic                       dst_hi_o,
  output logic [HALF_W-1:0]          half_res_o,
  output logic                       acc_wr_o,
  output logic [$clog2(NUM_ACC)-1:0] acc_idx_o,
  output logic [EXT_W-1:0]           acc_ext_o,
  output logic [2*HALF_W-1:0]        acc_word_o,
  output logic                       az_we_o,
  output logic                       az_o,
  output logic                       an_we_o,
  output logic                       an_o,
  output logic                       v_we_o,
  output logic                       v_o,
  output logic                       vs_set_o,
  output logic [NUM_ACC-1:0]         av_clr_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int IDX_W  = $clog2(NUM_ACC);
  localparam logic [HALF_W-1:0] SAT_NEG = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] SAT_POS = {1'b0, {(HALF_W-1){1'b1}}};

  shift_mode_e mode;
  assign mode = shift_mode_e'(mode_i);

  logic [HALF_W-1:0] half_op, half_res;
  logic              half_left, half_ovf;

  assign half_op = src_hi_i ? src_word_i[WORD_W-1:HALF_W] : src_word_i[HALF_W-1:0];

  half_shifter #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_half (
    .op_i   (half_op),
    .cnt_i  (count_i),
    .res_o  (half_res),
    .left_o (half_left),
    .ovf_o  (half_ovf)
  );

  logic [EXT_W-1:0]  a_ext;
  logic [WORD_W-1:0] a_word;
  logic              a_neg, a_zero;

  acc_shifter #(.EXT_W(EXT_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_acc (
    .ext_i  (acc_ext_i),
    .word_i (acc_word_i),
    .cnt_i  (count_i),
    .ext_o  (a_ext),
    .word_o (a_word),
    .neg_o  (a_neg),
    .zero_o (a_zero)
  );

  logic [NUM_ACC-1:0] av_clr_d;
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_avclr
    assign av_clr_d[g] = (mode == MODE_ACC) && (acc_idx_i == IDX_W'(g));
  end

  flag_upd_t flg_d, flg_q;
  always_comb begin
    flg_d = '0;
    if (mode == MODE_ACC) begin
      flg_d.az_we = 1'b1;
      flg_d.az    = a_zero;
      flg_d.an_we = 1'b1;
      flg_d.an    = a_neg;
    end else if (half_left) begin
      flg_d.az_we  = 1'b1;
      flg_d.az     = ~|half_res;
      flg_d.an_we  = 1'b1;
      flg_d.an     = half_res[HALF_W-1];
      flg_d.v_we   = 1'b1;
      flg_d.v      = half_ovf;
      flg_d.vs_set = half_ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      half_wr_o  <= 1'b0;
      acc_wr_o   <= 1'b0;
      flg_q      <= '0;
      av_clr_o   <= '0;
      dst_hi_o   <= 1'b0;
      half_res_o <= '0;
      acc_idx_o  <= '0;
      acc_ext_o  <= '0;
      acc_word_o <= '0;
    end else begin
      valid_o   <= valid_i;
      half_wr_o <= valid_i && (mode == MODE_HALF);
      acc_wr_o  <= valid_i && (mode == MODE_ACC);
      flg_q     <= valid_i ? flg_d : '0;
      av_clr_o  <= valid_i ? av_clr_d : '0;
      if (valid_i) begin
        dst_hi_o   <= dst_hi_i;
        half_res_o <= half_res;
        acc_idx_o  <= acc_idx_i;
        acc_ext_o  <= a_ext;
        acc_word_o <= a_word;
      end
    end
  end

  assign az_we_o  = flg_q.az_we;
  assign az_o     = flg_q.az;
  assign an_we_o  = flg_q.an_we;
  assign an_o     = flg_q.an;
  assign v_we_o   = flg_q.v_we;
  assign v_o      = flg_q.v;
  assign vs_set_o = flg_q.vs_set;

  AST_SAT_ON_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni) (half_wr_o && v_we_o && v_o) |-> (half_res_o == SAT_NEG || half_res_o == SAT_POS)) else $error("sat value"); // R3
  AST_VS_TRACKS_V: assert property (@(posedge clk_i) disable iff (!rst_ni) v_we_o |-> (vs_set_o == v_o)) else $error("sticky"); // R4
  AST_VS_NEEDS_V: assert property (@(posedge clk_i) disable iff (!rst_ni) vs_set_o |-> v_we_o) else $error("sticky w/o v"); // R4
  AST_LEFT_AN: assert property (@(posedge clk_i) disable iff (!rst_ni) (half_wr_o && an_we_o) |-> (an_o == half_res_o[HALF_W-1])) else $error("an half"); // R5
  AST_RIGHT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (half_wr_o && !v_we_o) |-> !(az_we_o || an_we_o || vs_set_o)) else $error("right flags"); // R6
  AST_ACC_AN: assert property (@(posedge clk_i) disable iff (!rst_ni) acc_wr_o |-> (an_o == acc_ext_o[EXT_W-1])) else $error("acc an"); // R9
  AST_ACC_AZ: assert property (@(posedge clk_i) disable iff (!rst_ni) acc_wr_o |-> (az_o == ({acc_ext_o, acc_word_o} == '0))) else $error("acc az"); // R9
  AST_ACC_AVCLR: assert property (@(posedge clk_i) disable iff (!rst_ni) acc_wr_o |-> ($countones(av_clr_o) == 1 && !v_we_o)) else $error("av clr"); // R10
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o) else $error("latency"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_o |-> !(half_wr_o || acc_wr_o || az_we_o || an_we_o || v_we_o || vs_set_o || (|av_clr_o))) else $error("idle"); // R11
endmodule

// File: tb/dsp_imm_shift_test.sv
module dsp_imm_shift_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, mode_i = 1'b0, src_hi_i = 1'b0, dst_hi_i = 1'b0, acc_idx_i = 1'b0;
  logic [31:0] src_word_i = '0, acc_word_i = '0;
  logic [4:0]  count_i = '0;
  logic [7:0]  acc_ext_i = '0;
  logic        valid_o, half_wr_o, dst_hi_o, acc_wr_o, acc_idx_o;
  logic [15:0] half_res_o;
  logic [7:0]  acc_ext_o;
  logic [31:0] acc_word_o;
  logic        az_we_o, az_o, an_we_o, an_o, v_we_o, v_o, vs_set_o;
  logic [1:0]  av_clr_o;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_imm_shift uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .src_word_i(src_word_i), .src_hi_i(src_hi_i), .dst_hi_i(dst_hi_i),
    .count_i(count_i), .acc_idx_i(acc_idx_i), .acc_ext_i(acc_ext_i),
    .acc_word_i(acc_word_i), .valid_o(valid_o), .half_wr_o(half_wr_o),
    .dst_hi_o(dst_hi_o), .half_res_o(half_res_o), .acc_wr_o(acc_wr_o),
    .acc_idx_o(acc_idx_o), .acc_ext_o(acc_ext_o), .acc_word_o(acc_word_o),
    .az_we_o(az_we_o), .az_o(az_o), .an_we_o(an_we_o), .an_o(an_o),
    .v_we_o(v_we_o), .v_o(v_o), .vs_set_o(vs_set_o), .av_clr_o(av_clr_o)
  );

  typedef struct packed {
    logic [31:0] src;
    logic        hi;
    logic        dhi;
    logic [4:0]  cnt;
    logic [15:0] exp;
    logic        left;
    logic        ovf;
  } hvec_t;

  localparam int NV = 13;
  localparam hvec_t VECS [NV] = '{
    '{32'h0000_1234, 1'b0, 1'b0, 5'd20, 16'h7FFF, 1'b1, 1'b1}, // R3 positive sat, high bits lost
    '{32'h0000_0003, 1'b0, 1'b1, 5'd30, 16'h000C, 1'b1, 1'b0}, // R1 left by 2
    '{32'h0000_FFFF, 1'b0, 1'b0, 5'd17, 16'h8000, 1'b1, 1'b0}, // R1 -1 << 15 fits
    '{32'h0000_C000, 1'b0, 1'b0, 5'd31, 16'h8000, 1'b1, 1'b0}, // R3 exact fit at min
    '{32'h0000_BFFF, 1'b0, 1'b0, 5'd31, 16'h8000, 1'b1, 1'b1}, // R3 negative sat
    '{32'h0000_4000, 1'b0, 1'b0, 5'd31, 16'h7FFF, 1'b1, 1'b1}, // R3 bit15 flip only
    '{32'h0000_0000, 1'b0, 1'b0, 5'd25, 16'h0000, 1'b1, 1'b0}, // R5 zero result
    '{32'h8001_0004, 1'b1, 1'b0, 5'd8,  16'hFF80, 1'b0, 1'b0}, // R7 high half, R2
    '{32'h8001_0004, 1'b0, 1'b1, 5'd1,  16'h0002, 1'b0, 1'b0}, // R7 low half, R2
    '{32'h0000_8000, 1'b0, 1'b0, 5'd16, 16'hFFFF, 1'b0, 1'b0}, // R2 count 16 negative
    '{32'h0000_7FFF, 1'b0, 1'b0, 5'd16, 16'h0000, 1'b0, 1'b0}, // R2 count 16 positive
    '{32'h0000_1234, 1'b0, 1'b0, 5'd0,  16'h1234, 1'b0, 1'b0}, // R2 count 0
    '{32'h0001_8000, 1'b1, 1'b0, 5'd17, 16'h7FFF, 1'b1, 1'b1}  // R7 high half differs from low
  };

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_acc(input logic idx, input logic [7:0] ext, input logic [31:0] wrd, input logic [4:0] cnt,
                         input logic [7:0] e_ext, input logic [31:0] e_wrd);
    mode_i = 1'b1; acc_idx_i = idx; acc_ext_i = ext; acc_word_i = wrd; count_i = cnt;
    issue();
    chk(valid_o && acc_wr_o && !half_wr_o, "R11", "acc strobes", {valid_o, acc_wr_o, half_wr_o}, 3'b110);
    chk({acc_ext_o, acc_word_o} == {e_ext, e_wrd}, "R8", "acc result", {acc_ext_o, acc_word_o}, {e_ext, e_wrd});
    chk(an_we_o && an_o == e_ext[7], "R9", "acc an", {an_we_o, an_o}, {1'b1, e_ext[7]});
    chk(az_we_o && az_o == ({e_ext, e_wrd} == 40'd0), "R9", "acc az", {az_we_o, az_o}, {1'b1, ({e_ext, e_wrd} == 40'd0)});
    chk(!v_we_o && !vs_set_o, "R9", "acc v untouched", {v_we_o, vs_set_o}, 2'b00);
    chk(av_clr_o == (2'b01 << idx) && acc_idx_o == idx, "R10", "acc select", {av_clr_o, acc_idx_o}, {(2'b01 << idx), idx});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!valid_o && !half_wr_o && !acc_wr_o, "R12", "reset strobes", {valid_o, half_wr_o, acc_wr_o}, 3'b000);
    chk(!(az_we_o || an_we_o || v_we_o || vs_set_o) && av_clr_o == 2'b00, "R12", "reset flags",
        {az_we_o, an_we_o, v_we_o, vs_set_o, av_clr_o}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mode_i = 1'b0; src_word_i = VECS[i].src; src_hi_i = VECS[i].hi; dst_hi_i = VECS[i].dhi;
      count_i = VECS[i].cnt; acc_idx_i = 1'b0;
      issue();
      chk(valid_o && half_wr_o && !acc_wr_o, "R11", $sformatf("vec %0d strobes", i), {valid_o, half_wr_o, acc_wr_o}, 3'b110);
      chk(half_res_o == VECS[i].exp, VECS[i].left ? (VECS[i].ovf ? "R3" : "R1") : "R2",
          $sformatf("vec %0d result", i), half_res_o, VECS[i].exp);
      chk(dst_hi_o == VECS[i].dhi, "R7", $sformatf("vec %0d dst half", i), dst_hi_o, VECS[i].dhi);
      chk(av_clr_o == 2'b00, "R10", $sformatf("vec %0d av clr", i), av_clr_o, 2'b00);
      if (VECS[i].left) begin
        chk(v_we_o && v_o == VECS[i].ovf && vs_set_o == VECS[i].ovf, "R4", $sformatf("vec %0d v/vs", i),
            {v_we_o, v_o, vs_set_o}, {1'b1, VECS[i].ovf, VECS[i].ovf});
        chk(az_we_o && an_we_o && az_o == (VECS[i].exp == 16'h0) && an_o == VECS[i].exp[15], "R5",
            $sformatf("vec %0d az/an", i), {az_we_o, an_we_o, az_o, an_o},
            {1'b1, 1'b1, (VECS[i].exp == 16'h0), VECS[i].exp[15]});
      end else begin
        chk(!(az_we_o || an_we_o || v_we_o || vs_set_o), "R6", $sformatf("vec %0d no flags", i),
            {az_we_o, an_we_o, v_we_o, vs_set_o}, 4'b0000);
      end
    end

    // R11 idle cycle after an operation: no strobes
    @(negedge clk);
    chk(!valid_o && !half_wr_o && !acc_wr_o && !(az_we_o || an_we_o || v_we_o || vs_set_o) && av_clr_o == 2'b00,
        "R11", "idle quiet", {valid_o, half_wr_o, acc_wr_o, az_we_o, v_we_o}, 5'd0);

    // R8 R9 R10 accumulator mode
    run_acc(1'b1, 8'h80, 32'h0000_0000, 5'd4,  8'hF8, 32'h0000_0000);
    run_acc(1'b0, 8'h00, 32'h0000_00FF, 5'd8,  8'h00, 32'h0000_0000);
    run_acc(1'b1, 8'hFF, 32'hFFFF_FFFF, 5'd31, 8'hFF, 32'hFFFF_FFFF);
    run_acc(1'b0, 8'h12, 32'h3456_7890, 5'd0,  8'h12, 32'h3456_7890);
    run_acc(1'b0, 8'h7F, 32'hFFFF_FFFF, 5'd31, 8'h00, 32'h0000_00FF);

    // R12 reset mid-stream clears strobes
    mode_i = 1'b0; src_word_i = 32'h0000_4000; src_hi_i = 1'b0; count_i = 5'd31;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!valid_o && !half_wr_o && !v_we_o && !vs_set_o, "R12", "async reset", {valid_o, half_wr_o, v_we_o, vs_set_o}, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule